// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits between a memory controller's command scheduler and the column address pins of an SDRAM. It keeps a copy of the 13-bit mode word that the controller programs into the device. From that word it derives the burst length, the wrap order, the CAS latency and the single-write option. Once a read or write has been issued, it produces the column address for every beat of the burst.

Each burst starts with a one-cycle start strobe. The strobe carries a 9-bit starting column and a write flag. From the following cycle the block drives one column address per clock, marked valid, and flags the final beat with a last indication.

- For short bursts, the column bits above the burst size stay fixed. The low bits step through an aligned block, either by adding the beat index or by XOR-ing it in.
- A full-page burst walks all 512 columns and wraps around. It runs until the terminate input is raised.
- The terminate input also cuts short any shorter burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset the outputs are `col_vld` = 0, `col_last` = 0, `mode_err` = 0 and `cas_lat` = 2. The stored setup is a burst length of 1, sequential order and no single-write mode.
- R2: A `mode_ld` pulse with a legal word updates the setup from the next cycle. The word's fields are:
  - bits 2:0: burst length. 000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page.
  - bit 3: order. 0 = sequential, 1 = interleaved.
  - bits 6:4: CAS latency.
  - bits 8:7: mode. Must be 00.
  - bit 9: single-write.
  - bits 12:10: have no effect.
- R3: A loaded word is rejected in any of these cases: a length code 100–110, a length code 111 together with interleaved order, a CAS code other than 010 or 011, or mode bits other than 00. A rejected word raises `mode_err` for the cycle after the load and leaves the stored setup as it was.
- R4: `cas_lat` shows 2 for CAS code 010 and 3 for code 011, from the cycle after the load.
- R5: A start strobe sampled at a clock edge makes the first address valid after that edge. The block then gives one address per cycle, for 1, 2, 4 or 8 beats. `col_last` is high with the final address, and `col_vld` is low in the cycle after it.
- R6: In sequential order, bits above the block size equal the start column. The low k bits equal (start + beat) mod 2^k, where k = log2(length).
- R7: In interleaved order, bits above the block size equal the start column. The low k bits equal the start's low bits XOR the beat index.
- R8: A full-page burst adds one per beat across all 9 column bits, wraps from 511 to 0, and continues until terminated.
- R9: With a length of 1, exactly one beat equal to the start column is issued, and the order bit has no effect.
- R10: With single-write set, a write burst issues exactly one beat. A read burst still uses the programmed length.
- R11: While a burst is valid, `term` high makes the current address the last one (`col_last` high in that cycle). `col_vld` is low in the next cycle.
- R12: A start strobe arriving while a burst is valid is ignored. The running burst's addresses are unchanged and no extra beats appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ld | input | 1 | Load strobe for the mode word |
| mode_word | input | 13 | Mode word to decode and store |
| start | input | 1 | Burst start strobe |
| start_col | input | 9 | Starting column of the burst |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| term | input | 1 | Terminate the running burst at the current beat |
| col_addr | output | 9 | Column address of the current beat |
| col_vld | output | 1 | Column address valid |
| col_last | output | 1 | Current beat is the final one |
| cas_lat | output | 2 | Decoded CAS latency (2 or 3) |
| mode_err | output | 1 | One-cycle pulse for a rejected mode word |

## Verification
A mode load is sampled at one edge. `mode_err` and `cas_lat` are then due one cycle later, so the bench checks them just before the following edge.

A start strobe at edge N puts beat j on `col_addr` between edges N+j and N+j+1. The driver places the expected addresses in a queue in beat order. The monitor samples one nanosecond before every rising edge, pops an entry for each valid beat, and reports any valid beat that arrives with nothing expected. The driver raises `term` in the cycle in which the beat to be made last is visible, because `col_last` reacts to it within that same cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int SPAN_W = 4;

  typedef struct packed {
    logic [SPAN_W-1:0] span;       // log2 of block size, COL_W means full row
    logic              ilv;        // 1 = xor ordering
    logic              cas3;       // 1 = latency 3, 0 = latency 2
    logic              wr_single;  // writes access one location
  } burst_cfg_t;
endpackage

// File: rtl/mode_cfg.sv
module mode_cfg
  import burst_pkg::*;
#(
  parameter int MODE_W = 13,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [MODE_W-1:0] word,
  output burst_cfg_t        cfg,
  output logic              err
);
  localparam logic [SPAN_W-1:0] FULL_SPAN = SPAN_W'(COL_W);

  burst_cfg_t cfg_q, cfg_d, dec;
  logic       err_q, err_d;
  logic       len_ok, cas_ok, op_ok;

  // field decode
  always_comb begin
    dec.ilv       = word[3];
    dec.cas3      = word[4];
    dec.wr_single = word[9];
    len_ok        = 1'b1;
    unique case (word[2:0])
      3'b000:  dec.span = '0;
      3'b001:  dec.span = SPAN_W'(1);
      3'b010:  dec.span = SPAN_W'(2);
      3'b011:  dec.span = SPAN_W'(3);
      3'b111: begin
        dec.span = FULL_SPAN;
        len_ok   = !word[3];
      end
      default: begin
        dec.span = '0;
        len_ok   = 1'b0;
      end
    endcase
    cas_ok = (word[6:4] == 3'b010) || (word[6:4] == 3'b011);
    op_ok  = (word[8:7] == 2'b00);
  end

  // next state
  always_comb begin
    cfg_d = cfg_q;
    err_d = 1'b0;
    if (ld) begin
      if (len_ok && cas_ok && op_ok) cfg_d = dec;
      else                           err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg = cfg_q;
  assign err = err_q;

  AST_ERR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(cfg_q)); // R3
  AST_ERR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(ld)); // R3
  AST_CFG_MOVES_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(ld) && !err_q); // R2
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  burst_cfg_t       cfg,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             term,
  output logic [COL_W-1:0] col_addr,
  output logic             col_vld,
  output logic             col_last
);
  localparam logic [SPAN_W-1:0] FULL_SPAN = SPAN_W'(COL_W);

  logic             act_q, act_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             ilv_q, ilv_d;
  logic             fp_q, fp_d;
  logic [COL_W-1:0] cfg_mask, sum, xr;
  logic             single;

  // per-bit block mask from span
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign cfg_mask[i] = (cfg.span > SPAN_W'(i));
  end

  assign single = start_wr && cfg.wr_single;

  // per-bit column ordering: advancing bits inside block, fixed bits above
  assign sum = base_q + beat_q;
  assign xr  = base_q ^ beat_q;
  for (genvar i = 0; i < COL_W; i++) begin : g_addr
    assign col_addr[i] = mask_q[i] ? (ilv_q ? xr[i] : sum[i]) : base_q[i];
  end

  assign col_vld  = act_q;
  assign col_last = act_q && (term || (!fp_q && (beat_q == mask_q)));

  // next state
  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    beat_d = beat_q;
    mask_d = mask_q;
    ilv_d  = ilv_q;
    fp_d   = fp_q;
    if (act_q) begin
      if (col_last) act_d = 1'b0;
      else          beat_d = beat_q + 1'b1;
    end else if (start) begin
      act_d  = 1'b1;
      base_d = start_col;
      beat_d = '0;
      mask_d = single ? '0 : cfg_mask;
      ilv_d  = cfg.ilv;
      fp_d   = !single && (cfg.span == FULL_SPAN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      fp_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      beat_q <= beat_d;
      mask_q <= mask_d;
      ilv_q  <= ilv_d;
      fp_q   <= fp_d;
    end
  end

  AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |=> !col_vld); // R5
  AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    col_vld && term |-> col_last); // R11
  AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    col_vld && $past(col_vld) && !$past(col_last)
      |-> ((col_addr & ~mask_q) == ($past(col_addr) & ~mask_q))); // R6
  AST_BUSY_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    col_vld && !col_last |=> col_vld && $stable(base_q)); // R12
  AST_FULL_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    col_vld && fp_q && !ilv_q && $past(col_vld) && !$past(col_last)
      |-> col_addr == $past(col_addr) + 1'b1); // R8
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int MODE_W = 13,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_wr,
  input  logic              term,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_vld,
  output logic              col_last,
  output logic [1:0]        cas_lat,
  output logic              mode_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  burst_cfg_t cfg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mode_cfg #(.MODE_W(MODE_W), .COL_W(COL_W)) u_mode_cfg (
    .clk  (clk),
    .rst_n(rst_int_n),
    .ld   (mode_ld),
    .word (mode_word),
    .cfg  (cfg),
    .err  (mode_err)
  );

  burst_seq #(.COL_W(COL_W)) u_burst_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg      (cfg),
    .start    (start),
    .start_col(start_col),
    .start_wr (start_wr),
    .term     (term),
    .col_addr (col_addr),
    .col_vld  (col_vld),
    .col_last (col_last)
  );

  assign cas_lat = cfg.cas3 ? 2'd3 : 2'd2;

  AST_CAS_LEGAL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cas_lat == 2'd2) || (cas_lat == 2'd3)); // R4
endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  typedef struct {
    logic [8:0] addr;
    logic       last;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ld = 1'b0;
  logic [12:0] mode_word = '0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic       start_wr = 1'b0;
  logic       term = 1'b0;
  logic [8:0] col_addr;
  logic       col_vld, col_last, mode_err;
  logic [1:0] cas_lat;

  int checks = 0;
  int fails = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_wr(start_wr), .term(term),
    .col_addr(col_addr), .col_vld(col_vld), .col_last(col_last),
    .cas_lat(cas_lat), .mode_err(mode_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] beat_addr(input logic [8:0] b, input int j,
                                           input int span, input bit ilv);
    logic [8:0] m, off;
    m   = 9'((1 << span) - 1);
    off = ilv ? ((b & m) ^ 9'(j)) : (((b & m) + 9'(j)) & m);
    return (b & ~m) | (off & m);
  endfunction

  // monitor: samples 1 ns before each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #7;
      if (col_vld) begin
        if (q.size() == 0) begin
          check("R12 unexpected beat", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.req, " addr"}, col_addr, e.addr);
          check({e.req, " last"}, col_last, e.last);
        end
      end
    end
  end

  task automatic load(input logic [12:0] w, input bit exp_err, input int exp_cas,
                      input string req);
    @(negedge clk); #1;
    mode_ld = 1'b1; mode_word = w;
    @(negedge clk); #1;
    mode_ld = 1'b0;
    #2;
    check({req, " mode_err"}, mode_err, exp_err);
    check({req, " cas_lat"}, cas_lat, exp_cas);
    @(negedge clk); #3;
    check({req, " mode_err clears"}, mode_err, 0);
  endtask

  // n beats expected; cut>0 asserts term on beat cut-1
  task automatic burst(input logic [8:0] col, input bit wr, input int span,
                       input bit ilv, input int n, input int cut,
                       input bit poke, input string req);
    int total;
    total = (cut > 0) ? cut : n;
    for (int j = 0; j < total; j++) begin
      exp_t e;
      e.addr = beat_addr(col, j, span, ilv);
      e.last = (j == total - 1);
      e.req  = req;
      q.push_back(e);
    end
    @(negedge clk); #1;
    start = 1'b1; start_col = col; start_wr = wr;
    for (int j = 0; j < total; j++) begin
      @(negedge clk); #1;
      start = poke && (j == 1);
      start_col = ~col;
      term = (cut > 0) && (j == total - 1);
    end
    @(negedge clk); #1;
    start = 1'b0; term = 1'b0;
    repeat (2) @(negedge clk);
    check({req, " queue drained"}, q.size(), 0);
  endtask

  initial begin
    #(8 * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    check("R1 col_vld", col_vld, 0);
    check("R1 col_last", col_last, 0);
    check("R1 mode_err", mode_err, 0);
    check("R1 cas_lat", cas_lat, 2);
    burst(9'd77, 1'b0, 0, 1'b0, 1, 0, 1'b0, "R1 reset length 1");

    load(13'h033, 1'b0, 3, "R2 R4 len8 seq cas3");
    burst(9'd5, 1'b0, 3, 1'b0, 8, 0, 1'b0, "R6 seq len8 from 5");
    burst(9'd301, 1'b0, 3, 1'b0, 8, 0, 1'b0, "R6 seq len8 high block");
    burst(9'd300, 1'b0, 3, 1'b0, 8, 0, 1'b1, "R12 start while busy");

    load(13'h022, 1'b0, 2, "R4 len4 seq cas2");
    burst(9'd14, 1'b0, 2, 1'b0, 4, 0, 1'b0, "R5 seq len4");

    load(13'h03B, 1'b0, 3, "R2 len8 ilv");
    burst(9'd5, 1'b0, 3, 1'b1, 8, 0, 1'b0, "R7 ilv len8 from 5");
    load(13'h029, 1'b0, 2, "R2 len2 ilv");
    burst(9'd255, 1'b1, 1, 1'b1, 2, 0, 1'b0, "R7 ilv len2");

    load(13'h1C28, 1'b0, 2, "R2 upper bits ignored");
    burst(9'd200, 1'b0, 0, 1'b0, 1, 0, 1'b0, "R9 len1 ilv bit ignored");

    load(13'h037, 1'b0, 3, "R2 full page");
    burst(9'd509, 1'b0, 9, 1'b0, 0, 5, 1'b0, "R8 full page wrap");

    load(13'h033, 1'b0, 3, "R2 len8 again");
    burst(9'd2, 1'b0, 3, 1'b0, 8, 3, 1'b0, "R11 term len8");

    load(13'h034, 1'b1, 3, "R3 len code 100");
    load(13'h03F, 1'b1, 3, "R3 full page ilv");
    load(13'h043, 1'b1, 3, "R3 cas code 100");
    load(13'h0B3, 1'b1, 3, "R3 mode bits 01");
    load(13'h022 | 13'h080, 1'b1, 3, "R3 mode reserved cas2");
    burst(9'd9, 1'b0, 3, 1'b0, 8, 0, 1'b0, "R3 setup unchanged");

    load(13'h233, 1'b0, 3, "R2 single write");
    burst(9'd6, 1'b1, 0, 1'b0, 1, 0, 1'b0, "R10 write single");
    burst(9'd6, 1'b0, 3, 1'b0, 8, 0, 1'b0, "R10 read full length");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule